// File: doc/BRIEF.md
# USB Transmit Line Encoder

This block serialises outgoing packet bytes onto a USB-style differential line. It sends one line symbol per clock. Each symbol is J, K or single-ended zero (SE0). A byte-wide producer presents data with a valid flag and gets a one-cycle ready pulse whenever its byte is taken. The block starts every packet with a synchronisation pattern and sends the bytes least significant bit first. When the producer stops supplying bytes, it closes the packet with an end-of-packet pattern.

A two-bit mode input selects one of three behaviours:
- **Normal:** stuffing and NRZI coding are applied.
- **Raw:** stuffing and NRZI are bypassed, so each bit maps straight to a line level.
- **Non-driving:** the output enable is released, so the attached port looks disconnected.

Top module: `usb_tx_line_encoder`

## Requirements
- R1: While reset is asserted, and after it until a packet starts, the line shows J with `line_oe` low and `tx_ready` low.
- R2: In normal mode every packet begins with eight symbols K J K J K J K K. This is the bit pattern 0000000 then 1, sent in that order and NRZI coded from an idle J.
- R3: `tx_ready` is high for exactly one cycle per byte. That cycle is the last bit slot of the sync pattern or of the previous byte, and only while `tx_valid` is high. The byte on `tx_data` is taken at that edge and sent bit 0 first.
- R4: In normal mode a 0 bit toggles the line between J and K, and a 1 bit keeps the previous level.
- R5: In normal mode, after six consecutive 1 bits a 0 is inserted before NRZI coding. The count includes the final 1 of the sync pattern, runs across byte boundaries, and applies after the last byte of a packet.
- R6: If `tx_valid` is low at a refill slot, the packet ends after the current bit. The end is two SE0 symbols and one J symbol, after which `line_oe` drops.
- R7: Mode 2'b10 applies no stuffing and no NRZI: a 1 bit drives J and a 0 bit drives K. This includes the sync pattern, which becomes K K K K K K K J. The end-of-packet pattern is unchanged.
- R8: Modes 2'b01 and 2'b11 (mode bit 0 set) are non-driving. `line_oe` is low in the same cycle, no `tx_ready` is given, and `tx_valid` is ignored. A packet in progress is abandoned, and the next packet in a driving mode is encoded correctly from idle.
- R9: The choice between normal and raw coding is taken when the packet starts. A change between 2'b00 and 2'b10 during a packet has no effect until the next packet.
- R10: Line encoding on {`line_dp`,`line_dm`}: J = 2'b10, K = 2'b01, SE0 = 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line symbol per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | BYTE_W | Byte to transmit |
| tx_valid | input | 1 | Producer has a byte; low at a refill slot ends the packet |
| op_mode | input | 2 | 00 normal, 10 raw, 01/11 non-driving |
| tx_ready | output | 1 | Byte on tx_data is taken at this edge |
| line_dp | output | 1 | Positive line level |
| line_dm | output | 1 | Negative line level |
| line_oe | output | 1 | Transmitter drive enable |

## Verification
A wrong bit index or a wrong stuffing count appears on the line within one byte time, as a misplaced transition. Because of NRZI coding, a single wrong level flips every later symbol of the packet, so a comparison of the whole packet exposes it at once. A wrong refill decision shows up in the same packet in one of three ways: as a ready count that differs from the byte count, as a packet of the wrong length, or as an end-of-packet pattern that starts one symbol early or late. The bench sends every byte value through both coding modes and compares each packet symbol by symbol against a sequence built arithmetically.

// File: rtl/usb_tx_line_encoder.sv
module usb_tx_line_encoder #(
  parameter int BYTE_W  = 8,
  parameter int RUN_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic [1:0]        op_mode,
  output logic              tx_ready,
  output logic              line_dp,
  output logic              line_dm,
  output logic              line_oe
);
  localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int OW = $clog2(RUN_MAX + 1);
  localparam logic [IW-1:0] LAST = IW'(BYTE_W - 1);
  localparam logic [OW-1:0] RUN  = OW'(RUN_MAX);
  localparam logic [1:0] LS_J = 2'b10, LS_K = 2'b01, LS_SE0 = 2'b00;

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA, ST_EOP} state_t;

  state_t            st;
  logic [BYTE_W-1:0] shreg;
  logic [IW-1:0]     bidx;
  logic [OW-1:0]     ones;
  logic              lvl, byp, drain, oe_q;
  logic [1:0]        eop_n, ls_q;

  wire nodrive  = op_mode[0];
  wire in_bits  = (st == ST_SYNC) || (st == ST_DATA);
  wire stuff    = (st == ST_DATA) && !byp && (ones == RUN);
  wire cur_bit  = (st == ST_SYNC) ? (bidx == LAST) : (!stuff && shreg[0]);
  wire refill   = in_bits && !stuff && !drain && (bidx == LAST);
  wire lvl_nxt  = byp ? cur_bit : (cur_bit ? lvl : !lvl);
  wire [OW-1:0] ones_nxt = cur_bit ? ones + 1'b1 : '0;
  wire end_stuff = !byp && (ones_nxt == RUN);

  assign tx_ready = refill && tx_valid && !nodrive;
  assign line_oe  = oe_q && !nodrive;
  assign {line_dp, line_dm} = ls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; shreg <= '0; bidx <= '0; ones <= '0; lvl <= 1'b1;
      byp <= 1'b0; drain <= 1'b0; oe_q <= 1'b0; eop_n <= '0; ls_q <= LS_J;
    end else if (nodrive) begin
      st <= ST_IDLE; oe_q <= 1'b0; ls_q <= LS_J; lvl <= 1'b1;
      bidx <= '0; ones <= '0; drain <= 1'b0; eop_n <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          oe_q <= 1'b0; ls_q <= LS_J; lvl <= 1'b1;
          bidx <= '0; ones <= '0; drain <= 1'b0; eop_n <= '0;
          if (tx_valid) begin
            st  <= ST_SYNC;
            byp <= op_mode[1];
          end
        end
        ST_SYNC, ST_DATA: begin
          oe_q <= 1'b1;
          lvl  <= lvl_nxt;
          ls_q <= lvl_nxt ? LS_J : LS_K;
          ones <= byp ? '0 : ones_nxt;
          if (stuff) begin
            if (drain) st <= ST_EOP;
          end else begin
            bidx  <= (bidx == LAST) ? '0 : bidx + 1'b1;
            shreg <= shreg >> 1;
            if (bidx == LAST) begin
              if (tx_valid) begin
                shreg <= tx_data;
                st    <= ST_DATA;
              end else if (end_stuff) begin
                drain <= 1'b1;
              end else begin
                st <= ST_EOP;
              end
            end
          end
        end
        ST_EOP: begin
          oe_q  <= 1'b1;
          eop_n <= eop_n + 1'b1;
          if (eop_n == 2'd2) begin
            ls_q <= LS_J;
            st   <= ST_IDLE;
          end else begin
            ls_q <= LS_SE0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ready_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> (st == ST_DATA) && (bidx == '0));

  assert_stuff_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff && !nodrive) |=> (ls_q != $past(ls_q)));

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN);

  assert_eop_se0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EOP && eop_n != 2'd2 && !nodrive) |=> (ls_q == LS_SE0));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nodrive |=> (!oe_q && st == ST_IDLE));

  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_bits |=> (byp == $past(byp)));
endmodule

// File: tb/sim_usb_tx_line_encoder.sv
module sim_usb_tx_line_encoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] J = 2'b10, K = 2'b01, SE0 = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic [1:0] op_mode = 2'b00;
  logic tx_ready, line_dp, line_dm, line_oe;

  int checks = 0, errors = 0;
  logic [7:0] bytes_q [0:15];
  int nbytes;
  logic [1:0] exp_sym [0:399];
  logic [1:0] got_sym [0:399];
  int exp_len, got_len, ready_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_tx_line_encoder u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .op_mode(op_mode), .tx_ready(tx_ready), .line_dp(line_dp),
    .line_dm(line_dm), .line_oe(line_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_expected(input logic raw_mode);
    logic raw [0:399];
    int nr = 0, ones = 0;
    logic b, lv;
    for (int i = 0; i < 8 + 8 * nbytes; i++) begin
      b = (i < 8) ? (i == 7) : bytes_q[(i - 8) / 8][(i - 8) % 8];
      raw[nr] = b; nr = nr + 1;
      if (!raw_mode) begin
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin raw[nr] = 1'b0; nr = nr + 1; ones = 0; end
      end
    end
    lv = 1'b1;
    for (int i = 0; i < nr; i++) begin
      if (raw_mode) lv = raw[i];
      else if (!raw[i]) lv = !lv;
      exp_sym[i] = lv ? J : K;
    end
    exp_sym[nr] = SE0; exp_sym[nr+1] = SE0; exp_sym[nr+2] = J;
    exp_len = nr + 3;
  endtask

  task automatic run_packet(input logic [1:0] mode, input logic [1:0] alt, input int sw_after, input string tag);
    int bad;
    op_mode = mode;
    build_expected(mode[1]);
    ready_cnt = 0; got_len = 0;
    fork
      begin
        int k = 0;
        tx_data = bytes_q[0]; tx_valid = 1'b1;
        while (k < nbytes) begin
          @(negedge clk);
          if (tx_ready) begin
            ready_cnt++;
            @(posedge clk); #1;
            k++;
            if (k < nbytes) tx_data = bytes_q[k]; else tx_valid = 1'b0;
          end
        end
      end
      begin
        int w = 0;
        @(negedge clk);
        while (!line_oe && w < 60) begin @(negedge clk); w++; end
        while (line_oe && got_len < 400) begin
          got_sym[got_len] = {line_dp, line_dm};
          got_len++;
          @(negedge clk);
        end
      end
      begin
        if (sw_after > 0) begin
          repeat (sw_after) @(posedge clk);
          #1 op_mode = alt;
        end
      end
    join
    chk(got_len == exp_len, "R6 packet length", got_len, exp_len);
    bad = -1;
    for (int i = 0; i < exp_len && i < got_len; i++)
      if (bad < 0 && got_sym[i] !== exp_sym[i]) bad = i;
    if (bad >= 0) chk(1'b0, tag, int'(got_sym[bad]), int'(exp_sym[bad]));
    else chk(1'b1, tag, 0, 0);
    chk(ready_cnt == nbytes, "R3 ready count", ready_cnt, nbytes);
    op_mode = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    chk({line_dp, line_dm} == J, "R1 R10 reset line J", {line_dp, line_dm}, J);
    chk(!line_oe && !tx_ready, "R1 reset oe/ready", {line_oe, tx_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!line_oe && {line_dp, line_dm} == J, "R1 idle after reset", {line_oe, line_dp, line_dm}, 3'b010);

    nbytes = 1; bytes_q[0] = 8'hA5;
    run_packet(2'b00, 2'b00, 0, "R4 symbols");
    for (int i = 0; i < 8; i++)
      chk(got_sym[i] == ((i == 7) ? K : ((i % 2 == 0) ? K : J)), "R2 sync symbol", got_sym[i], (i == 7) ? K : ((i % 2 == 0) ? K : J));

    for (int v = 0; v < 256; v++) begin
      bytes_q[0] = 8'(v);
      run_packet(2'b00, 2'b00, 0, "R4 R5 normal byte sweep");
    end
    for (int v = 0; v < 256; v++) begin
      bytes_q[0] = 8'(v);
      run_packet(2'b10, 2'b10, 0, "R7 raw byte sweep");
    end
    bytes_q[0] = 8'h00;
    run_packet(2'b10, 2'b10, 0, "R7 raw");
    for (int i = 0; i < 8; i++)
      chk(got_sym[i] == ((i == 7) ? J : K), "R7 raw sync", got_sym[i], (i == 7) ? J : K);

    nbytes = 3; bytes_q[0] = 8'hFF; bytes_q[1] = 8'hFF; bytes_q[2] = 8'hFF;
    run_packet(2'b00, 2'b00, 0, "R5 stuffing across bytes and at end");
    nbytes = 2; bytes_q[0] = 8'hFC; bytes_q[1] = 8'h3F;
    run_packet(2'b00, 2'b00, 0, "R5 run spanning boundary");
    nbytes = 1; bytes_q[0] = 8'h7E;
    run_packet(2'b00, 2'b00, 0, "R5 run inside byte");
    bytes_q[0] = 8'h3F;
    run_packet(2'b00, 2'b00, 0, "R5 run counting sync bit");
    nbytes = 2; bytes_q[0] = 8'hFF; bytes_q[1] = 8'hFF;
    run_packet(2'b10, 2'b10, 0, "R7 raw no stuffing");
    nbytes = 5;
    for (int i = 0; i < 5; i++) bytes_q[i] = 8'(8'h13 * (i + 1) + 8'h80);
    run_packet(2'b00, 2'b00, 0, "R3 R4 multi-byte");

    nbytes = 4; for (int i = 0; i < 4; i++) bytes_q[i] = 8'hF0 ^ 8'(i);
    run_packet(2'b00, 2'b10, 12, "R9 normal held after switch to raw");
    run_packet(2'b10, 2'b00, 12, "R9 raw held after switch to normal");

    for (int m = 1; m < 4; m += 2) begin
      op_mode = 2'(m); tx_valid = 1'b1; tx_data = 8'h55; seen = 0;
      repeat (30) begin
        @(negedge clk);
        if (tx_ready || line_oe) seen++;
      end
      chk(seen == 0, "R8 non-driving ignores tx_valid", seen, 0);
      tx_valid = 1'b0; op_mode = 2'b00;
      repeat (3) @(negedge clk);
    end

    op_mode = 2'b00; tx_valid = 1'b1; tx_data = 8'hFF;
    repeat (14) @(posedge clk);
    #1 op_mode = 2'b01; tx_valid = 1'b0;
    #1 chk(!line_oe, "R8 abort releases drive at once", line_oe, 0);
    seen = 0;
    repeat (4) begin @(negedge clk); if (line_oe || tx_ready) seen++; end
    chk(seen == 0, "R8 stays released", seen, 0);
    op_mode = 2'b00;
    repeat (3) @(negedge clk);
    chk(!line_oe && {line_dp, line_dm} == J, "R8 idle after abort", {line_oe, line_dp, line_dm}, 3'b010);
    nbytes = 1; bytes_q[0] = 8'hC3;
    run_packet(2'b00, 2'b00, 0, "R8 clean packet after abort");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule